// File: doc/BRIEF.md
# Triangular Lane Skew Register Array

This block takes a vector of one-bit lanes and delays each lane by a different number of clock cycles. Lane 0 is delayed by one cycle, lane 1 by two, and so on, with each lane one cycle behind the lane below it. The lanes therefore leave the block staggered like a staircase.

A typical use is feeding a row of data into the edge of a systolic array, where each processing column must see its operand one cycle after its neighbour. Another use is re-aligning lanes that were skewed the other way upstream. The block is built only from registers: each lane has its own shift chain, and each chain is one stage longer than the chain of the lane below it. No stage exists that is not on the path to an output.

The lanes never stall and never exchange bits. An active-high synchronous reset empties every chain to zero.

Top module: `lane_skew`

## Requirements
- R1: Output bit 0 equals input bit 0 as sampled at the previous rising clock edge.
- R2: For every lane i, output bit i equals input bit i as sampled i+1 rising edges earlier, provided no reset edge fell inside that window.
- R3: A rising edge with `rst` high clears every stage of every lane, so all output bits read 0 immediately after that edge.
- R4: After reset is released, output bit i stays 0 for the first i edges that have `rst` low, and then shows data that entered after the release.
- R5: Lanes are independent: a bit driven on one lane never appears on any other output bit.
- R6: Each output bit shows the deepest stage of its chain only. A single-cycle pulse on input lane i appears as exactly one single-cycle pulse on output lane i, and a new bit is delivered on every cycle without stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1     | Rising-edge clock for all stages |
| rst  | input  | 1     | Active-high synchronous clear of all stages |
| din  | input  | LANES | One bit per lane; bit i enters the chain of lane i |
| dout | output | LANES | Bit i is the last stage of lane i, delayed by i+1 cycles |

## Verification
Each output bit i is due exactly i+1 rising edges after its input was sampled, so the bench drives inputs on the falling edge and compares all lanes shortly after every rising edge against a queue of past input vectors, indexed by lane number. A reset edge replaces the queue contents with zero vectors, so the zeros expected for the first i cycles after release follow from the same indexing. Single-lane pulses, all-ones, alternating and random patterns, plus a reset in the middle of a stream, exercise the delay of each lane, lane isolation and the reset corner.

// File: rtl/lane_skew.sv
module lane_skew #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [g:0] stg;

    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= din[g];
      end
    end else begin : g_deep
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[g-1:0], din[g]};
      end
    end

    assign dout[g] = stg[g];
  end

endmodule

// File: rtl/lane_skew_chk.sv
module lane_skew_chk #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] din,
  input logic [LANES-1:0] dout
);

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q == 1'b1)
      assert_clear_after_reset_R3: assert (dout == '0)
        else $error("R3: outputs not cleared after reset edge");
  end

  assert_lane0_delay_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) == 1'b0) |-> (dout[0] == $past(din[0])));

  if (LANES > 1) begin : g_multi
    assert_lane1_delay_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) == 1'b0 && $past(rst, 2) == 1'b0) |-> (dout[1] == $past(din[1], 2)));

    assert_upper_zero_after_release_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(rst, 2) == 1'b1 && $past(rst) == 1'b0) |-> (dout[LANES-1:1] == '0));
  end

endmodule

bind lane_skew lane_skew_chk #(.LANES(LANES)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .dout (dout)
);

// File: tb/tb_lane_skew.sv
`timescale 1ns/1ps
module tb_lane_skew;
  localparam int LANES = 3;
  localparam int HALF  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] din = '0;
  logic [LANES-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string tag = "R3";
  int since_rst = 0;

  logic [LANES-1:0] hist[$];

  lane_skew #(.LANES(LANES)) dut (.clk(clk), .rst(rst), .din(din), .dout(dout));

  always #HALF clk = ~clk;

  task automatic step(input logic r, input logic [LANES-1:0] d, input string t);
    @(negedge clk);
    rst = r;
    din = d;
    @(posedge clk);
    if (r) begin
      hist.delete();
      for (int k = 0; k < LANES; k++) hist.push_front('0);
      since_rst = 0;
    end else begin
      hist.push_front(d);
      if (hist.size() > LANES) void'(hist.pop_back());
      since_rst++;
    end
    #1;
    for (int i = 0; i < LANES; i++) begin
      string req;
      if (r) req = "R3";
      else if (since_rst <= i) req = "R4";
      else if (t != "") req = t;
      else req = (i == 0) ? "R1" : "R2";
      checks++;
      if (dout[i] !== hist[i][i]) begin
        errors++;
        $display("FAIL %s lane %0d: dout=%b expected=%b", req, i, dout[i], hist[i][i]);
      end
    end
  endtask

  initial begin
    repeat (3) step(1'b1, '1, "R3");
    repeat (40) step(1'b0, LANES'($urandom), "");
    for (int l = 0; l < LANES; l++) begin
      step(1'b0, LANES'(1) << l, "R5");
      repeat (LANES + 1) step(1'b0, '0, "R6");
    end
    repeat (LANES + 2) step(1'b0, '1, "R2");
    for (int k = 0; k < 10; k++) step(1'b0, (k % 2) ? '1 : '0, "R6");
    step(1'b1, '1, "R3");
    repeat (LANES + 1) step(1'b0, '1, "R4");
    repeat (60) step(1'b0, LANES'($urandom), "");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule